// File: doc/BRIEF.md
# Sliced Quad-Rail Handshake Link Stage

This block is a clocked model of one register stage on a 32-bit link. The link is cut into sixteen narrow lanes, and each lane carries two data bits. A lane sends each 2-bit value as a one-of-four code: exactly one of four rail wires is high. All four rails low is the spacer, the empty state between symbols. Each lane also has an end-of-frame wire and its own acknowledge wire. A link port therefore has eighty forward wires and sixteen acknowledge wires.

No detector waits for the whole word to complete. Each lane runs its own four-phase handshake on both sides of the stage:
- A valid code arrives and the stage raises the lane acknowledge.
- The sender returns the rails to spacer and the stage drops the acknowledge.

Because of this, one lane can be several symbols ahead of another inside a frame.

Each lane has one holding slot. A captured symbol sits on the downstream rails until the next stage acknowledges it. The lane then returns its output to spacer. It takes no new symbol until that downstream acknowledge has gone low again.

A lane that receives a code with more than one rail high sets its own sticky code-error flag. It does not acknowledge that code.

Top module: `slc_link_stage`

## Requirements
- R1: While reset is high, and on the first cycle after it, every acknowledge, every downstream rail, every downstream end-of-frame bit and every code-error flag is low.
- R2: Lane i uses rails [4i+3:4i], and value v is sent by driving rail bit v of the lane high. A lane whose acknowledge is low, whose holding slot is empty (downstream rails spacer) and whose downstream acknowledge is low captures a one-hot code at a clock edge. After that edge its acknowledge is high and its downstream rails carry the captured code.
- R3: A lane whose acknowledge is high drops it at the first clock edge at which its upstream rails are spacer. While the rails stay non-spacer, the acknowledge stays high.
- R4: A code with two or more rails high sets the lane's code-error flag at that edge. The code is neither acknowledged nor captured. The flag stays set until reset, and the lane goes on handling later valid codes normally.
- R5: A held symbol stays unchanged on the downstream rails and end-of-frame bit while the lane's downstream acknowledge is low. The edge after that acknowledge is seen high, the lane's downstream rails and end-of-frame bit are low.
- R6: While a lane's holding slot is full, or its downstream acknowledge is high, a valid upstream code is not acknowledged.
- R7: Lanes are independent: a stalled lane does not delay the handshakes of any other lane.
- R8: Each lane's downstream rails are always either spacer or one-hot.
- R9: The end-of-frame bit is captured together with its code and is driven only while the lane holds a symbol. An end-of-frame bit that arrives with a spacer has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_rail | input | 64 | Upstream rails, four per lane |
| up_eof | input | 16 | Upstream end-of-frame, one per lane |
| up_ack | output | 16 | Acknowledge back to the sender, one per lane |
| dn_rail | output | 64 | Downstream rails, four per lane |
| dn_eof | output | 16 | Downstream end-of-frame, one per lane |
| dn_ack | input | 16 | Acknowledge from the next stage, one per lane |
| code_err | output | 16 | Sticky multi-hot code flag, one per lane |

## Verification
The properties assume that both neighbours follow the four-phase rules:
- The sender holds a code until it sees the acknowledge, and then holds spacer until the acknowledge falls.
- The next stage raises its acknowledge only while this lane's downstream rails are non-spacer, and drops it only after they return to spacer.

The random producers and consumers in the bench are built as per-lane state machines that obey exactly these rules. They break the code rule on purpose only by presenting a short multi-hot burst while a lane is idle. Lanes stall and resume at independent random moments, so the lanes drift apart.

// File: rtl/slc_pkg.sv
package slc_pkg;

    localparam int unsigned RAIL_W = 4;
    localparam int unsigned BITS_PER_LANE = 2;

    typedef logic [RAIL_W-1:0] rail_t;

    typedef struct packed {
        logic  eof;
        rail_t rail;
    } lane_sym_t;

    typedef enum logic [1:0] {
        CODE_SPACER = 2'd0,
        CODE_VALID  = 2'd1,
        CODE_BAD    = 2'd2
    } code_kind_e;

    // 2-bit value to one-of-four rails
    function automatic rail_t sym_encode(input logic [BITS_PER_LANE-1:0] v);
        rail_t r;
        r = '0;
        r[v] = 1'b1;
        return r;
    endfunction

    // one-of-four rails back to a 2-bit value (lowest set rail wins)
    function automatic logic [BITS_PER_LANE-1:0] sym_decode(input rail_t r);
        logic [BITS_PER_LANE-1:0] v;
        v = '0;
        for (int k = RAIL_W - 1; k >= 0; k--) begin
            if (r[k]) v = BITS_PER_LANE'(k);
        end
        return v;
    endfunction

    function automatic int unsigned rail_count(input rail_t r);
        int unsigned n;
        n = 0;
        for (int k = 0; k < RAIL_W; k++) n += int'(r[k]);
        return n;
    endfunction

endpackage

// File: rtl/slc_code_check.sv
module slc_code_check
    import slc_pkg::*;
(
    input  rail_t      rail_i,
    output code_kind_e kind_o,
    output logic [BITS_PER_LANE-1:0] value_o
);

    int unsigned hot;

    always_comb begin
        hot = rail_count(rail_i);
        if (hot == 0)      kind_o = CODE_SPACER;
        else if (hot == 1) kind_o = CODE_VALID;
        else               kind_o = CODE_BAD;
        value_o = sym_decode(rail_i);
    end

endmodule

// File: rtl/slc_lane.sv
module slc_lane
    import slc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_sym_t in_sym,
    output logic      up_ack,
    output lane_sym_t out_sym,
    input  logic      dn_ack,
    output logic      code_err
);

    code_kind_e kind;
    logic [BITS_PER_LANE-1:0] in_val;
    logic      ack_q;
    lane_sym_t hold_q;
    logic      err_q;
    logic      slot_full;
    logic      take;
    logic      drain;

    slc_code_check u_chk (
        .rail_i  (in_sym.rail),
        .kind_o  (kind),
        .value_o (in_val)
    );

    always_comb begin
        slot_full = (hold_q.rail != '0);
        take      = !ack_q && (kind == CODE_VALID) && !slot_full && !dn_ack;
        drain     = slot_full && dn_ack;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q  <= 1'b0;
            hold_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (take) begin
                hold_q <= in_sym;
                ack_q  <= 1'b1;
            end else begin
                if (ack_q && kind == CODE_SPACER) ack_q <= 1'b0;
                if (drain) hold_q <= '0;
            end
            if (kind == CODE_BAD) err_q <= 1'b1;
        end
    end

    assign up_ack   = ack_q;
    assign out_sym  = hold_q;
    assign code_err = err_q;

    AST_ACK_ON_CODE:   assert property (@(posedge clk) disable iff (rst)
        $rose(ack_q) |-> $past(rail_count(in_sym.rail) == 1));               // R2
    AST_ACK_ON_SPACER: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_q) |-> $past(in_sym.rail == '0));                          // R3
    AST_ERR_STICKY:    assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);                                                    // R4
    AST_HOLD_STABLE:   assert property (@(posedge clk) disable iff (rst)
        (hold_q.rail != '0 && !dn_ack) |=> $stable(hold_q));                 // R5
    AST_NO_TAKE_BUSY:  assert property (@(posedge clk) disable iff (rst)
        (!ack_q && (hold_q.rail != '0 || dn_ack)) |=> !ack_q);               // R6
    AST_OUT_LEGAL:     assert property (@(posedge clk) disable iff (rst)
        $countones(hold_q.rail) <= 1);                                       // R8
    AST_EOF_WITH_SYM:  assert property (@(posedge clk) disable iff (rst)
        (hold_q.rail == '0) |-> !hold_q.eof);                                // R9

endmodule

// File: rtl/slc_link_stage.sv
module slc_link_stage
    import slc_pkg::*;
#(
    parameter int unsigned LANES = 16,
    localparam int unsigned RW = LANES * RAIL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [RW-1:0]    up_rail,
    input  logic [LANES-1:0] up_eof,
    output logic [LANES-1:0] up_ack,
    output logic [RW-1:0]    dn_rail,
    output logic [LANES-1:0] dn_eof,
    input  logic [LANES-1:0] dn_ack,
    output logic [LANES-1:0] code_err
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_sym_t in_s;
        lane_sym_t out_s;

        assign in_s.rail = up_rail[g*RAIL_W +: RAIL_W];
        assign in_s.eof  = up_eof[g];

        slc_lane u_lane (
            .clk      (clk),
            .rst      (rst),
            .in_sym   (in_s),
            .up_ack   (up_ack[g]),
            .out_sym  (out_s),
            .dn_ack   (dn_ack[g]),
            .code_err (code_err[g])
        );

        assign dn_rail[g*RAIL_W +: RAIL_W] = out_s.rail;
        assign dn_eof[g]                   = out_s.eof;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (up_ack == '0 && dn_rail == '0 && code_err == '0)); // R1

endmodule

// File: tb/slc_link_stage_tb.sv
module slc_link_stage_tb_top;

    localparam int L = 16;

    logic           clk = 1'b0;
    logic           rst;
    logic [4*L-1:0] up_rail;
    logic [L-1:0]   up_eof;
    logic [L-1:0]   up_ack;
    logic [4*L-1:0] dn_rail;
    logic [L-1:0]   dn_eof;
    logic [L-1:0]   dn_ack;
    logic [L-1:0]   code_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    slc_link_stage #(.LANES(L)) dut_i (
        .clk(clk), .rst(rst),
        .up_rail(up_rail), .up_eof(up_eof), .up_ack(up_ack),
        .dn_rail(dn_rail), .dn_eof(dn_eof), .dn_ack(dn_ack),
        .code_err(code_err)
    );

    // reference model built from the requirements
    logic [L-1:0]   m_ack, m_eof, m_err;
    logic [4*L-1:0] m_rail;

    always @(posedge clk) begin
        if (rst) begin
            m_ack = '0; m_eof = '0; m_err = '0; m_rail = '0;
        end else begin
            for (int l = 0; l < L; l++) begin : mdl
                logic [3:0] r;
                int c;
                r = up_rail[4*l +: 4];
                c = $countones(r);
                if (c > 1) m_err[l] = 1'b1;
                if (!m_ack[l] && c == 1 && m_rail[4*l +: 4] == 4'b0 && !dn_ack[l]) begin
                    m_rail[4*l +: 4] = r;
                    m_eof[l] = up_eof[l];
                    m_ack[l] = 1'b1;
                end else begin
                    if (m_ack[l] && c == 0) m_ack[l] = 1'b0;
                    if (m_rail[4*l +: 4] != 4'b0 && dn_ack[l]) begin
                        m_rail[4*l +: 4] = 4'b0;
                        m_eof[l] = 1'b0;
                    end
                end
            end
        end
    end

    function automatic logic [3:0] enc(input int v);
        return 4'b0001 << v;
    endfunction

    function automatic bit lanes_legal(input logic [4*L-1:0] r);
        for (int l = 0; l < L; l++) if ($countones(r[4*l +: 4]) > 1) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic put(input int l, input logic [3:0] r, input logic e);
        up_rail[4*l +: 4] = r;
        up_eof[l] = e;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    // random producer / consumer state
    int pst [L];
    int pwt [L];

    initial begin
        rst = 1'b1; up_rail = '0; up_eof = '0; dn_ack = '0;
        step(); step();
        chk(up_ack == '0 && dn_rail == '0 && dn_eof == '0 && code_err == '0, "R1 reset",
            {up_ack, dn_rail}, 0);
        rst = 1'b0;
        step();
        chk(up_ack == '0 && dn_rail == '0 && code_err == '0, "R1 after reset", {up_ack, dn_rail}, 0);

        // R2 capture on lane 0 value 2
        put(0, enc(2), 1'b0);
        step();
        chk(up_ack == 16'h0001, "R2 ack", up_ack, 16'h0001);
        chk(dn_rail[3:0] == 4'b0100, "R2 dn rails", dn_rail[3:0], 4'b0100);
        // R3 spacer drops ack, R5 hold remains
        put(0, 4'b0, 1'b1);
        step();
        chk(up_ack[0] == 1'b0, "R3 ack low", up_ack[0], 0);
        chk(dn_rail[3:0] == 4'b0100 && dn_eof[0] == 1'b0, "R5 held / R9 eof on spacer ignored",
            {dn_eof[0], dn_rail[3:0]}, 5'b00100);
        // R6 slot full
        put(0, enc(1), 1'b1);
        step(); step();
        chk(up_ack[0] == 1'b0, "R6 slot full", up_ack[0], 0);
        chk(dn_rail[3:0] == 4'b0100, "R5 stable", dn_rail[3:0], 4'b0100);
        dn_ack[0] = 1'b1;
        step();
        chk(dn_rail[3:0] == 4'b0 && dn_eof[0] == 1'b0, "R5 drain", {dn_eof[0], dn_rail[3:0]}, 0);
        step();
        chk(up_ack[0] == 1'b0, "R6 dn ack high", up_ack[0], 0);
        dn_ack[0] = 1'b0;
        step();
        chk(up_ack[0] == 1'b1 && dn_rail[3:0] == 4'b0010 && dn_eof[0] == 1'b1, "R9 eof captured / R2",
            {up_ack[0], dn_eof[0], dn_rail[3:0]}, 6'b110010);
        put(0, 4'b0, 1'b0);
        step();
        dn_ack[0] = 1'b1;
        step();
        dn_ack[0] = 1'b0;

        // R4 multi-hot on lane 5
        put(5, 4'b0011, 1'b0);
        step();
        chk(code_err == 16'h0020 && up_ack[5] == 1'b0 && dn_rail[23:20] == 4'b0, "R4 flag",
            {code_err, up_ack[5], dn_rail[23:20]}, {16'h0020, 5'b0});
        put(5, 4'b0, 1'b0);
        step();
        chk(code_err[5] == 1'b1, "R4 sticky", code_err[5], 1);
        put(5, enc(3), 1'b0);
        step();
        chk(up_ack[5] == 1'b1 && dn_rail[23:20] == 4'b1000, "R4 lane still works",
            {up_ack[5], dn_rail[23:20]}, 5'b11000);
        put(5, 4'b0, 1'b0);
        step();
        dn_ack[5] = 1'b1;
        step();
        dn_ack[5] = 1'b0;

        // R7 lane 3 stalled while lane 4 cycles twice
        put(3, enc(0), 1'b0);
        step();
        put(3, 4'b0, 1'b0);
        step();
        put(3, enc(1), 1'b0);
        for (int k = 0; k < 2; k++) begin
            put(4, enc(k + 1), 1'b0);
            step();
            chk(up_ack[4] == 1'b1 && up_ack[3] == 1'b0, "R7 independent", {up_ack[4], up_ack[3]}, 2'b10);
            put(4, 4'b0, 1'b0);
            step();
            dn_ack[4] = 1'b1;
            step();
            dn_ack[4] = 1'b0;
        end
        chk(dn_rail[15:12] == 4'b0001, "R7 stalled lane holds", dn_rail[15:12], 4'b0001);
        dn_ack[3] = 1'b1;
        step();
        dn_ack[3] = 1'b0;
        step();
        chk(up_ack[3] == 1'b1 && dn_rail[15:12] == 4'b0010, "R7 resumes", {up_ack[3], dn_rail[15:12]}, 5'b10010);
        put(3, 4'b0, 1'b0);
        step();
        dn_ack[3] = 1'b1;
        step();
        dn_ack[3] = 1'b0;
        step();

        // random phase with four-phase producers and consumers
        void'($urandom(32'h5EED_1234));
        for (int l = 0; l < L; l++) begin pst[l] = 0; pwt[l] = 0; end
        for (int cyc = 0; cyc < 4000; cyc++) begin
            chk(up_ack == m_ack && dn_rail == m_rail && dn_eof == m_eof && code_err == m_err,
                "R2 R3 R4 R5 R6 R9 model", {up_ack, dn_rail, code_err}, {m_ack, m_rail, m_err});
            chk(lanes_legal(dn_rail), "R8 legal output", dn_rail, 0);
            for (int l = 0; l < L; l++) begin
                case (pst[l])
                    0: begin
                        put(l, 4'b0, ($urandom % 2) == 1);
                        if (pwt[l] > 0) pwt[l]--;
                        else if (($urandom % 60) == 0) begin
                            put(l, 4'b0101 << ($urandom % 2), 1'b0);
                            pst[l] = 3;
                        end else begin
                            put(l, enc($urandom % 4), ($urandom % 6) == 0);
                            pst[l] = 1;
                        end
                    end
                    1: if (up_ack[l]) begin put(l, 4'b0, 1'b0); pst[l] = 2; end
                    2: if (!up_ack[l]) begin pwt[l] = $urandom % 4; pst[l] = 0; end
                    default: begin put(l, 4'b0, 1'b0); pst[l] = 0; end
                endcase
                if (!dn_ack[l] && dn_rail[4*l +: 4] != 4'b0 && ($urandom % 3) == 0) dn_ack[l] = 1'b1;
                else if (dn_ack[l] && dn_rail[4*l +: 4] == 4'b0 && ($urandom % 2) == 0) dn_ack[l] = 1'b0;
            end
            step();
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule